// File: doc/BRIEF.md
# Register-Based Burst Memory with Selectable Beat Order and Read Latency

This block is a small synchronous memory built from flip-flops, read and written in bursts of up to four beats. A start strobe registers a full address, and that address is the first beat. Each advance strobe after it moves to the next beat. Only the two lowest address bits take part in the burst. They follow either a wrapping increment or an XOR pattern against the start value. The upper address bits stay where the start put them.

Four static control inputs shape the timing:
- one picks the beat order;
- one picks whether read data comes straight from the array register (flow-through) or through one more register (pipelined);
- one picks whether deselection empties the output after one clock or after two;
- one puts the block in standby.

A fifth input decides whether the ninth bit of each byte lane is stored and returned.

Read data leaves on `rdata` qualified by `rvalid`. This output stream has no ready input: the memory cannot be stalled. A consumer must take each word in the cycle that `rvalid` is high. Cycles with no read data show `rvalid` low and `rdata` all zero. The write side has no handshake. A beat with `we` high stores `wdata` in the clock edge of that beat.

Top module: `sbsram_core`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is 0, and every stored word reads as zero.
- R2: A clock edge with `sleep`=0, `ce`=1 and `start`=1 makes `addr` the current beat and starts a new burst, even if `adv` is also high. `adv` moves a burst only when `ce`=1, `start`=0, and a burst has been started and not ended by a deselect.
- R3: With `order_ilv`=0 and start low bits s, beat k (k=0..3) uses low bits (s+k) mod 4. The upper address bits stay those of the start address. Example: s=2 gives 2,3,0,1.
- R4: With `order_ilv`=1, beat k uses low bits s XOR k. Example: s=1 gives 1,0,3,2.
- R5: The advance after the fourth beat returns the low bits to the start value s, and the sequence then repeats.
- R6: On a write beat, lane i data bits [9i+7:9i] are stored only when `be[i]`=1. Lanes with `be[i]`=0 keep their old contents.
- R7: With `par_en`=1, bit 9i+8 of lane i is stored under `be[i]` and read back. With `par_en`=0, those bits read as 0 and writes to them are dropped. The stored bit reappears once `par_en` returns to 1.
- R8: With `out_pipe`=0, a read beat registered at edge k drives `rvalid`=1 and the word on `rdata` in the cycle after edge k.
- R9: With `out_pipe`=1, the same word and `rvalid` appear one cycle later than in R8.
- R10: A cycle whose output stage holds no read result shows `rvalid`=0 and `rdata`=0. Write beats and idle cycles produce no output word.
- R11: With `desel_single`=1, an edge with `ce`=0 empties the first output stage. `ce`=0 also ends the burst, so later `adv` pulses do nothing until the next start.
- R12: With `desel_single`=0, the first edge with `ce`=0 keeps the last read word in the first output stage for one more cycle. The stage empties at the second such edge.
- R13: While `sleep`=1, `rvalid`=0 and `rdata`=0. Reads, writes, starts and advances are ignored and both output stages are cleared. Stored data and the burst position are kept, and the burst resumes on the first edge with `sleep`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_ilv | input | 1 | Beat order: 0 wrapping increment, 1 XOR |
| out_pipe | input | 1 | Read latency: 0 flow-through, 1 pipelined |
| desel_single | input | 1 | Deselect timing: 1 one clock, 0 two clocks |
| sleep | input | 1 | Standby when high |
| par_en | input | 1 | Ninth bit per lane stored and returned when high |
| ce | input | 1 | Chip enable; low deselects |
| we | input | 1 | Beat is a write when high, a read when low |
| be | input | BYTES | Per-lane write enables |
| start | input | 1 | Register `addr` and begin a burst |
| adv | input | 1 | Advance to the next beat |
| addr | input | ADDR_W | Start address |
| wdata | input | 9*BYTES | Write data, lane i at [9i+8:9i], bit 9i+8 is the ninth bit |
| rdata | output | 9*BYTES | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest condition to reach from the ports is the deselect hold. It needs a read beat, then a first edge with `ce` low while the output stage is still full, in dual mode and outside standby. It also needs pipelined latency to show the held word shifted by one stage. Directed sequences build this case in both deselect modes and both latencies. Random traffic then mixes deselects, sleep pulses and advances across a stale burst at a rate that covers the wrap after four beats. A bench model predicts every cycle's output from the requirements.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANE_W = 9;

  // Low address bits of beat k for a burst that began at s
  function automatic logic [1:0] beat_low(input logic ilv, input logic [1:0] s,
                                          input logic [1:0] k);
    return ilv ? (s ^ k) : (s + k);
  endfunction
endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
  import sbsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step,
  input  logic       ilv,
  input  logic [1:0] start_lo,
  output logic [1:0] beat_lo
);
  logic [1:0] seed_q, cnt_q, cur_q;

  always_comb begin
    if (start) beat_lo = start_lo;
    else       beat_lo = beat_low(ilv, seed_q, cnt_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
      cnt_q  <= '0;
      cur_q  <= '0;
    end else if (start) begin
      seed_q <= start_lo;
      cnt_q  <= '0;
      cur_q  <= start_lo;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
      cur_q  <= beat_lo;
    end
  end

  // R2: a start loads the given low bits as the current beat
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cur_q == $past(start_lo));
  // R3: linear advance moves the low bits by one
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !ilv) |=> cur_q == $past(cur_q) + 2'd1);
  // R5: the advance after the fourth beat returns to the seed
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && cnt_q == 2'd3) |=> cur_q == seed_q);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTES-1:0]          be,
  input  logic [BYTES*LANE_W-1:0]   wdata,
  input  logic                      par_en,
  output logic [BYTES*LANE_W-1:0]   rd_word
);
  localparam int DW    = BYTES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur_word, merged, par_mask;

  assign cur_word = mem[addr];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam int LO = i * LANE_W;
    assign merged[LO +: LANE_W-1] = be[i] ? wdata[LO +: LANE_W-1]
                                          : cur_word[LO +: LANE_W-1];
    assign merged[LO+LANE_W-1]    = (be[i] && par_en) ? wdata[LO+LANE_W-1]
                                                      : cur_word[LO+LANE_W-1];
    assign par_mask[LO +: LANE_W] = {par_en, {(LANE_W-1){1'b1}}};

    // R6: a lane whose enable is low keeps its data bits
    a_r6_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[i]) |=> mem[$past(addr)][LO +: LANE_W-1]
                            == $past(cur_word[LO +: LANE_W-1]));
    // R7: with the ninth bit disabled, a write leaves it untouched
    a_r7_par_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !par_en) |=> mem[$past(addr)][LO+LANE_W-1]
                             == $past(cur_word[LO+LANE_W-1]));
  end

  assign rd_word = cur_word & par_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (wr_en) begin
      mem[addr] <= merged;
    end
  end
endmodule

// File: rtl/sbsram_outpath.sv
module sbsram_outpath #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          pipe,
  input  logic          single_desel,
  input  logic          desel,
  input  logic          rd_beat,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] s1_d, s2_d;
  logic          s1_v, s2_v, held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_d <= '0; s1_v <= 1'b0; held_q <= 1'b0;
      s2_d <= '0; s2_v <= 1'b0;
    end else if (sleep) begin
      s1_d <= '0; s1_v <= 1'b0; held_q <= 1'b0;
      s2_d <= '0; s2_v <= 1'b0;
    end else begin
      s2_d <= s1_d;
      s2_v <= s1_v;
      if (rd_beat) begin
        s1_d <= rd_word; s1_v <= 1'b1; held_q <= 1'b0;
      end else if (desel && !single_desel && s1_v && !held_q) begin
        held_q <= 1'b1;
      end else begin
        s1_d <= '0; s1_v <= 1'b0; held_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (sleep) begin
      rdata = '0; rvalid = 1'b0;
    end else if (pipe) begin
      rdata = s2_d; rvalid = s2_v;
    end else begin
      rdata = s1_d; rvalid = s1_v;
    end
  end

  // R8: a flow-through read shows up in the next cycle
  a_r8_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && !pipe && !sleep) |=> (rvalid || sleep || pipe));
  // R11: single-cycle deselect empties the first stage at once
  a_r11_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && desel && single_desel && !rd_beat) |=> !s1_v);
  // R12: dual-cycle deselect holds the last word one more cycle
  a_r12_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && desel && !single_desel && s1_v && !held_q && !rd_beat)
      |=> (s1_v && $stable(s1_d)));
  // R13: standby clears the output stage
  a_r13_standby_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_v);
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     order_ilv,
  input  logic                     out_pipe,
  input  logic                     desel_single,
  input  logic                     sleep,
  input  logic                     par_en,
  input  logic                     ce,
  input  logic                     we,
  input  logic [BYTES-1:0]         be,
  input  logic                     start,
  input  logic                     adv,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTES*LANE_W-1:0]  wdata,
  output logic [BYTES*LANE_W-1:0]  rdata,
  output logic                     rvalid
);
  localparam int DW    = BYTES * LANE_W;
  localparam int HI_W  = ADDR_W - 2;

  logic            active_q;
  logic [HI_W-1:0] base_q;
  logic            start_g, step_g, access, wr_en, rd_beat;
  logic [1:0]      beat_lo;
  logic [ADDR_W-1:0] acc_addr;
  logic [DW-1:0]   rd_word;

  assign start_g  = !sleep && ce && start;
  assign step_g   = !sleep && ce && !start && adv && active_q;
  assign access   = start_g || step_g;
  assign wr_en    = access && we;
  assign rd_beat  = access && !we;
  assign acc_addr = start_g ? addr : {base_q, beat_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
    end else if (!sleep) begin
      if (start_g) begin
        active_q <= 1'b1;
        base_q   <= addr[ADDR_W-1:2];
      end else if (!ce) begin
        active_q <= 1'b0;
      end
    end
  end

  sbsram_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_g),
    .step     (step_g),
    .ilv      (order_ilv),
    .start_lo (addr[1:0]),
    .beat_lo  (beat_lo)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (acc_addr),
    .be      (be),
    .wdata   (wdata),
    .par_en  (par_en),
    .rd_word (rd_word)
  );

  sbsram_outpath #(.DW(DW)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .pipe         (out_pipe),
    .single_desel (desel_single),
    .desel        (!ce),
    .rd_beat      (rd_beat),
    .rd_word      (rd_word),
    .rdata        (rdata),
    .rvalid       (rvalid)
  );

  // R11: a deselect ends the burst, so a following lone advance touches nothing
  a_r11_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ce) |=> !step_g);
  // R13: standby keeps the burst alive
  a_r13_keep_burst: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> active_q == $past(active_q));
endmodule

// File: tb/sbsram_core_test.sv
module sbsram_core_test;
  localparam int ADDR_W = 6;
  localparam int BYTES  = 2;
  localparam int DW     = BYTES * 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic order_ilv = 0, out_pipe = 0, desel_single = 1, sleep = 0, par_en = 1;
  logic ce = 0, we = 0, start = 0, adv = 0;
  logic [BYTES-1:0]  be = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic              rvalid;

  int ntests = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sbsram_core #(.ADDR_W(ADDR_W), .BYTES(BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .order_ilv(order_ilv), .out_pipe(out_pipe),
    .desel_single(desel_single), .sleep(sleep), .par_en(par_en), .ce(ce),
    .we(we), .be(be), .start(start), .adv(adv), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid));

  // bench model state
  logic [DW-1:0] mm [DEPTH];
  logic [DW-1:0] s1d, s2d;
  logic s1v, s2v, held, m_act;
  logic [1:0] m_s, m_k;
  logic [ADDR_W-3:0] m_base;

  function automatic logic [1:0] lo_of(input logic ilv, input logic [1:0] s,
                                       input logic [1:0] k);
    return ilv ? (s ^ k) : 2'(s + k);
  endfunction

  function automatic logic [DW-1:0] visible(input logic [DW-1:0] w, input logic pe);
    logic [DW-1:0] r = w;
    for (int i = 0; i < BYTES; i++) if (!pe) r[i*9+8] = 1'b0;
    return r;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
      input logic [DW-1:0] d, input logic [BYTES-1:0] en, input logic pe);
    logic [DW-1:0] r = old;
    for (int i = 0; i < BYTES; i++) if (en[i]) begin
      r[i*9 +: 8] = d[i*9 +: 8];
      if (pe) r[i*9+8] = d[i*9+8];
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < DEPTH; w++) mm[w] = '0;
    s1d = '0; s2d = '0; s1v = 0; s2v = 0; held = 0; m_act = 0;
    m_s = 0; m_k = 0; m_base = '0;
  endtask

  task automatic model_edge();
    logic acc;
    logic [ADDR_W-1:0] a;
    acc = 0; a = '0;
    if (sleep) begin
      s1d = '0; s2d = '0; s1v = 0; s2v = 0; held = 0;
    end else begin
      s2d = s1d; s2v = s1v;
      if (ce && start) begin
        acc = 1; a = addr; m_s = addr[1:0]; m_base = addr[ADDR_W-1:2];
        m_k = 0; m_act = 1;
      end else if (ce && adv && m_act) begin
        m_k = m_k + 2'd1; acc = 1; a = {m_base, lo_of(order_ilv, m_s, m_k)};
      end
      if (!ce) m_act = 0;
      if (acc && we) mm[a] = merge(mm[a], wdata, be, par_en);
      if (acc && !we) begin
        s1d = visible(mm[a], par_en); s1v = 1; held = 0;
      end else if (!ce && !desel_single && s1v && !held) begin
        held = 1;
      end else begin
        s1d = '0; s1v = 0; held = 0;
      end
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step(input string tag);
    logic [DW-1:0] ed;
    logic ev;
    string t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (sleep) begin ev = 0; ed = '0; end
    else if (out_pipe) begin ev = s2v; ed = s2d; end
    else begin ev = s1v; ed = s1d; end
    t = tag;
    if (t == "") t = sleep ? "R13" : (!ev ? "R10" : (out_pipe ? "R9" : "R8"));
    ntests++;
    if (rvalid !== ev || rdata !== ed) begin
      nfail++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               t, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic drive(input logic c, input logic st, input logic ad,
                       input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DW-1:0] d, input logic [BYTES-1:0] b);
    ce = c; start = st; adv = ad; we = w; addr = a; wdata = d; be = b;
  endtask

  task automatic nop(input string tag);
    drive(1, 0, 0, 0, addr, '0, '1);
    step(tag);
  endtask

  // burst of four beats, write or read, then two idle clocks
  task automatic burst(input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DW-1:0] d0, input string tag);
    drive(1, 1, 0, w, a, d0, '1); step(tag);
    for (int k = 1; k < 4; k++) begin
      drive(1, 0, 1, w, a, DW'(d0 + k * 18'h01111), '1); step(tag);
    end
    nop(tag); nop(tag);
  endtask

  task automatic rd1(input logic [ADDR_W-1:0] a, input string tag);
    drive(1, 1, 0, 0, a, '0, '1); step(tag);
    nop(tag); nop(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1"); step("R1");
    // R1: stored words read as zero after reset
    rd1(6'h21, "R1");

    // R3: linear burst from low bits 2 lands on 2,3,0,1 in the same row
    order_ilv = 0;
    burst(1, 6'h0A, 18'h00101, "R3");
    for (int j = 0; j < 4; j++) rd1(6'h08 + j, "R3");
    burst(0, 6'h0A, '0, "R3");

    // R4: XOR burst from low bits 1 lands on 1,0,3,2
    order_ilv = 1;
    burst(1, 6'h15, 18'h10202, "R4");
    for (int j = 0; j < 4; j++) rd1(6'h14 + j, "R4");
    burst(0, 6'h17, '0, "R4");

    // R5: fifth and later advances repeat from the start value
    order_ilv = 0;
    drive(1, 1, 0, 0, 6'h0B, '0, '1); step("R5");
    for (int k = 0; k < 6; k++) begin drive(1, 0, 1, 0, 6'h0B, '0, '1); step("R5"); end
    nop("R5");

    // R2: start wins over a simultaneous advance
    drive(1, 1, 1, 0, 6'h16, '0, '1); step("R2");
    drive(1, 1, 1, 0, 6'h09, '0, '1); step("R2");
    nop("R2"); nop("R2");

    // R6: per-lane write enable
    drive(1, 1, 0, 1, 6'h08, 18'h3FFFF, 2'b01); step("R6");
    drive(1, 1, 0, 1, 6'h09, 18'h3FFFF, 2'b10); step("R6");
    nop("R6"); rd1(6'h08, "R6"); rd1(6'h09, "R6");

    // R7: ninth bit off drops writes and reads zero, then reappears
    drive(1, 1, 0, 1, 6'h30, 18'h3FFFF, '1); step("R7");
    par_en = 0;
    rd1(6'h30, "R7");
    drive(1, 1, 0, 1, 6'h30, 18'h00000, '1); step("R7");
    rd1(6'h30, "R7");
    par_en = 1;
    rd1(6'h30, "R7");

    // R9 / R8: pipelined then flow-through latency on back-to-back beats
    out_pipe = 1; burst(0, 6'h0A, '0, "R9");
    out_pipe = 0; burst(0, 6'h14, '0, "R8");

    // R11: single deselect; adv after deselect does nothing
    desel_single = 1;
    drive(1, 1, 0, 0, 6'h0A, '0, '1); step("R11");
    drive(0, 0, 0, 0, 6'h0A, '0, '1); step("R11");
    drive(1, 0, 1, 0, 6'h0A, '0, '1); step("R11");
    nop("R11");
    out_pipe = 1;
    drive(1, 1, 0, 0, 6'h0B, '0, '1); step("R11");
    drive(0, 0, 0, 0, 6'h0B, '0, '1); step("R11"); step("R11"); step("R11");

    // R12: dual deselect holds one more cycle, both latencies
    desel_single = 0;
    for (int p = 0; p < 2; p++) begin
      out_pipe = p[0];
      drive(1, 1, 0, 0, 6'h15, '0, '1); step("R12");
      drive(0, 0, 0, 0, 6'h15, '0, '1); step("R12"); step("R12"); step("R12");
      nop("R12");
    end
    desel_single = 1; out_pipe = 0;

    // R13: standby mid-burst ignores writes and keeps the burst position
    drive(1, 1, 0, 0, 6'h08, '0, '1); step("R13");
    drive(1, 0, 1, 0, 6'h08, '0, '1); step("R13");
    sleep = 1;
    drive(1, 0, 1, 1, 6'h08, 18'h2AAAA, '1); step("R13");
    drive(1, 1, 0, 1, 6'h09, 18'h15555, '1); step("R13");
    sleep = 0;
    drive(1, 0, 1, 0, 6'h08, '0, '1); step("R13");
    drive(1, 0, 1, 0, 6'h08, '0, '1); step("R13");
    nop("R13"); rd1(6'h09, "R13");

    // constrained random traffic, modes changed every so often
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0) begin
        order_ilv = 1'($urandom); out_pipe = 1'($urandom);
        desel_single = 1'($urandom); par_en = ($urandom % 4) != 0;
      end
      sleep = ($urandom % 25) == 0;
      drive(($urandom % 8) != 0, ($urandom % 5) == 0, ($urandom % 3) != 0,
            ($urandom % 3) == 0, ADDR_W'($urandom), DW'($urandom),
            BYTES'($urandom));
      step("");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule